// File: doc/BRIEF.md
# Pin to Message Interrupt Delivery Engine

This block turns interrupt requests on a set of input pins into message-signalled interrupts. Each pin has its own 64-bit routing entry, which an outside register file holds and presents on a flat input bus. When a pin is strobed, the engine records the request. It then picks one pending pin and builds a 32-bit address and a 32-bit data word from that pin's entry and a base address set by a parameter. It offers the message on a valid/ready output.

The message leaves through a valid/ready handshake. The engine raises `msg_valid` once a message is loaded. While `msg_ready` is low, the message stays unchanged. The transfer completes on the first rising clock edge where both are high. In the same cycle, the engine pulses strobes that tell the register file to clear the delivery-status bit of the sent entry. For a level-triggered entry it also pulses a strobe to set that entry's remote-IRR bit.

The engine tracks remote IRR for each pin. A level-triggered pin with remote IRR set is held back until an end-of-interrupt (EOI) arrives carrying that pin's vector. A new message is loaded only when the output stage is empty, so back-to-back messages are at least two cycles apart.

Top module: `pin_msg_engine`

## Requirements
- R1: The low address word is BASE_ADDR OR (destination byte << 12) OR (1 << 3) OR (destination-mode bit << 2). The destination byte is entry bits 63:56 and the destination-mode bit is entry bit 11. The high address word is always zero.
- R2: The data word is (trigger bit << 15) OR (remote IRR << 14) OR (delivery mode << 8) OR vector. The vector is entry bits 7:0, the delivery mode is entry bits 10:8 (codes 0 to 7 passed through unchanged) and the trigger bit is entry bit 15.
- R3: A pin whose mask bit (entry bit 16) is 1 produces no message. A request that arrives while the pin is masked is discarded, so it does not appear after a later unmask.
- R4: When a level-triggered message (trigger bit 1) completes its handshake, `irr_set_o` pulses that pin's bit in that cycle. The message data carries bit 15 set.
- R5: After that, further requests on the same level pin are held and not sent. They are sent only after an EOI with a matching vector clears the pin's remote IRR.
- R6: While `eoi_valid` is high, `irr_clr_o` pulses the bit of every level-triggered pin whose vector equals `eoi_vector`. Edge-triggered pins and pins whose vector differs get no pulse.
- R7: `dstat_clr_o` pulses exactly the sent pin's bit in the cycle the handshake completes, and is zero in every other cycle.
- R8: When several pins are pending, the lowest pin index is sent first.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, the address and the data stay unchanged.
- R10: The full 8-bit destination byte is used even when the destination-mode bit is 0.
- R11: A request on a pin whose message is already loaded but not yet accepted is latched. It produces one further message.
- R12: After reset, `msg_valid` and all strobes are low and no pin is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_req | input | NPINS | One-cycle request strobe per pin |
| entries_i | input | NPINS*64 | Routing entries; pin i is at bits [64*i+63 : 64*i] |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Sink accepts the message |
| msg_addr_lo | output | 32 | Low message address word |
| msg_addr_hi | output | 32 | High message address word (zero) |
| msg_data | output | 32 | Message data word |
| dstat_clr_o | output | NPINS | Delivery-status clear strobe, per pin |
| irr_set_o | output | NPINS | Remote-IRR set strobe, per pin |
| irr_clr_o | output | NPINS | Remote-IRR clear strobe, per pin |

## Verification
The bench builds the engine with 24 pins and a base address of 0xFEE00000. With 24 pins, both end indices (0 and 23) can be exercised in priority races. The base address leaves bits 19:0 clear, so every destination, hint and mode bit is visible in the low address word. A level pin and an edge pin share one vector, which shows whether an EOI separates them by trigger mode. Long back-pressure stalls show the hold rule and the handling of a repeat request while a message is in flight.

// File: rtl/pmsg_pkg.sv
package pmsg_pkg;

  localparam int ENT_W     = 64;
  localparam int VEC_LSB   = 0;
  localparam int DMODE_LSB = 8;
  localparam int DSTM_BIT  = 11;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  localparam int HINT_BIT       = 3;
  localparam int ADDR_DSTM_BIT  = 2;
  localparam int ADDR_DEST_LSB  = 12;
  localparam int DATA_TRIG_BIT  = 15;
  localparam int DATA_IRR_BIT   = 14;
  localparam int DATA_DMODE_LSB = 8;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMGMT  = 3'b010,
    DM_RREAD  = 3'b011,
    DM_NMASK  = 3'b100,
    DM_RESET  = 3'b101,
    DM_START  = 3'b110,
    DM_EXTERN = 3'b111
  } dmode_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       dstm;
    dmode_e     dmode;
    logic [7:0] vec;
  } route_t;

  function automatic route_t unpack_route(input logic [ENT_W-1:0] e);
    route_t r;
    r.dest  = e[DEST_LSB +: 8];
    r.mask  = e[MASK_BIT];
    r.level = e[TRIG_BIT];
    r.dstm  = e[DSTM_BIT];
    r.dmode = dmode_e'(e[DMODE_LSB +: 3]);
    r.vec   = e[VEC_LSB +: 8];
    return r;
  endfunction

endpackage

// File: rtl/pmsg_pin_state.sv
module pmsg_pin_state #(
  parameter int NPINS = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   req_i,
  input  logic [NPINS-1:0]   mask_i,
  input  logic [NPINS-1:0]   level_i,
  input  logic [NPINS*8-1:0] vec_i,
  input  logic [NPINS-1:0]   load_i,
  input  logic [NPINS-1:0]   set_i,
  input  logic               eoi_valid_i,
  input  logic [7:0]         eoi_vec_i,
  output logic [NPINS-1:0]   elig_o,
  output logic [NPINS-1:0]   irr_o,
  output logic [NPINS-1:0]   irr_clr_o
);

  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] irr_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic hit;
    logic do_set;
    logic do_clr;

    assign do_set = set_i[i];
    assign hit    = eoi_valid_i && level_i[i] && (vec_i[i*8 +: 8] == eoi_vec_i);
    assign do_clr = hit && !do_set;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= (pend_q[i] && !load_i[i]) || (req_i[i] && !mask_i[i]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irr_q[i] <= 1'b0;
      end else if (do_set) begin
        irr_q[i] <= 1'b1;
      end else if (do_clr) begin
        irr_q[i] <= 1'b0;
      end
    end

    assign elig_o[i]    = pend_q[i] && !mask_i[i] && !(level_i[i] && irr_q[i]);
    assign irr_clr_o[i] = do_clr;
  end

  assign irr_o = irr_q;

endmodule

// File: rtl/pmsg_pick.sv
module pmsg_pick #(
  parameter int NPINS = 24
) (
  input  logic [NPINS-1:0] cand_i,
  output logic [NPINS-1:0] gnt_o,
  output logic             any_o
);

  always_comb begin
    gnt_o = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |cand_i;

endmodule

// File: rtl/pmsg_out_stage.sv
module pmsg_out_stage
  import pmsg_pkg::*;
#(
  parameter int          NPINS     = 24,
  parameter logic [31:0] BASE_ADDR = 32'hFEE0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NPINS-1:0] load_gnt_i,
  input  route_t           route_i,
  input  logic             irr_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [31:0]      addr_lo_o,
  output logic [31:0]      data_o,
  output logic [NPINS-1:0] owner_o,
  output logic             owner_level_o
);

  logic [31:0] addr_n;
  logic [31:0] data_n;
  logic        fire;

  always_comb begin
    addr_n = BASE_ADDR;
    addr_n[ADDR_DEST_LSB +: 8] = addr_n[ADDR_DEST_LSB +: 8] | route_i.dest;
    addr_n[HINT_BIT]      = 1'b1;
    addr_n[ADDR_DSTM_BIT] = addr_n[ADDR_DSTM_BIT] | route_i.dstm;
  end

  always_comb begin
    data_n = '0;
    data_n[DATA_TRIG_BIT]       = route_i.level;
    data_n[DATA_IRR_BIT]        = irr_i;
    data_n[DATA_DMODE_LSB +: 3] = route_i.dmode;
    data_n[7:0]                 = route_i.vec;
  end

  assign fire = valid_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o       <= 1'b0;
      addr_lo_o     <= '0;
      data_o        <= '0;
      owner_o       <= '0;
      owner_level_o <= 1'b0;
    end else if (load_i) begin
      valid_o       <= 1'b1;
      addr_lo_o     <= addr_n;
      data_o        <= data_n;
      owner_o       <= load_gnt_i;
      owner_level_o <= route_i.level;
    end else if (fire) begin
      valid_o <= 1'b0;
      owner_o <= '0;
    end
  end

endmodule

// File: rtl/pin_msg_engine.sv
module pin_msg_engine
  import pmsg_pkg::*;
#(
  parameter int          NPINS     = 24,
  parameter logic [31:0] BASE_ADDR = 32'hFEE0_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pin_req,
  input  logic [NPINS*ENT_W-1:0]   entries_i,
  input  logic                     eoi_valid,
  input  logic [7:0]               eoi_vector,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [31:0]              msg_addr_lo,
  output logic [31:0]              msg_addr_hi,
  output logic [31:0]              msg_data,
  output logic [NPINS-1:0]         dstat_clr_o,
  output logic [NPINS-1:0]         irr_set_o,
  output logic [NPINS-1:0]         irr_clr_o
);

  logic [NPINS-1:0]   mask_v;
  logic [NPINS-1:0]   level_v;
  logic [NPINS*8-1:0] vec_v;
  route_t             route_a [NPINS];

  for (genvar i = 0; i < NPINS; i++) begin : g_unpack
    assign route_a[i]        = unpack_route(entries_i[i*ENT_W +: ENT_W]);
    assign mask_v[i]         = route_a[i].mask;
    assign level_v[i]        = route_a[i].level;
    assign vec_v[i*8 +: 8]   = route_a[i].vec;
  end

  logic [NPINS-1:0] elig;
  logic [NPINS-1:0] irr;
  logic [NPINS-1:0] gnt;
  logic             any;
  logic             load;
  logic [NPINS-1:0] load_vec;
  logic [NPINS-1:0] owner;
  logic             owner_level;
  logic             fire;
  logic [NPINS-1:0] done_vec;
  logic [NPINS-1:0] set_vec;
  route_t           sel_route;
  logic             sel_irr;

  assign load     = any && !msg_valid;
  assign load_vec = gnt & {NPINS{load}};
  assign fire     = msg_valid && msg_ready;
  assign done_vec = owner & {NPINS{fire}};
  assign set_vec  = done_vec & {NPINS{owner_level}};

  always_comb begin
    sel_route = '0;
    sel_irr   = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (gnt[i]) begin
        sel_route = route_a[i];
        sel_irr   = irr[i];
      end
    end
  end

  pmsg_pin_state #(.NPINS(NPINS)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (pin_req),
    .mask_i      (mask_v),
    .level_i     (level_v),
    .vec_i       (vec_v),
    .load_i      (load_vec),
    .set_i       (set_vec),
    .eoi_valid_i (eoi_valid),
    .eoi_vec_i   (eoi_vector),
    .elig_o      (elig),
    .irr_o       (irr),
    .irr_clr_o   (irr_clr_o)
  );

  pmsg_pick #(.NPINS(NPINS)) u_pick (
    .cand_i (elig),
    .gnt_o  (gnt),
    .any_o  (any)
  );

  pmsg_out_stage #(.NPINS(NPINS), .BASE_ADDR(BASE_ADDR)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load),
    .load_gnt_i    (gnt),
    .route_i       (sel_route),
    .irr_i         (sel_irr),
    .valid_o       (msg_valid),
    .ready_i       (msg_ready),
    .addr_lo_o     (msg_addr_lo),
    .data_o        (msg_data),
    .owner_o       (owner),
    .owner_level_o (owner_level)
  );

  assign msg_addr_hi = '0;
  assign dstat_clr_o = done_vec;
  assign irr_set_o   = set_vec;

endmodule

// File: rtl/pmsg_checks.sv
module pmsg_checks #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr_lo,
  input logic [31:0]      msg_addr_hi,
  input logic [31:0]      msg_data,
  input logic             eoi_valid,
  input logic [NPINS-1:0] dstat_clr_o,
  input logic [NPINS-1:0] irr_set_o,
  input logic [NPINS-1:0] irr_clr_o
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr_lo) && $stable(msg_data)));

  assert_hiaddr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr_hi == 32'h0 && msg_addr_lo[3]));

  assert_dstat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |-> ($countones(dstat_clr_o) == 1));

  assert_dstat_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_ready) |-> (dstat_clr_o == '0));

  assert_irrset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_set_o != '0) |-> (irr_set_o == dstat_clr_o && msg_data[15]));

  assert_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_clr_o != '0) |-> eoi_valid);

endmodule

bind pin_msg_engine pmsg_checks #(.NPINS(NPINS)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_addr_lo (msg_addr_lo),
  .msg_addr_hi (msg_addr_hi),
  .msg_data    (msg_data),
  .eoi_valid   (eoi_valid),
  .dstat_clr_o (dstat_clr_o),
  .irr_set_o   (irr_set_o),
  .irr_clr_o   (irr_clr_o)
);

// File: tb/pin_msg_engine_test.sv
module pin_msg_engine_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          NP         = 24;
  localparam logic [31:0] BASE       = 32'hFEE0_0000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0]        pin_req = '0;
  logic [NP*64-1:0]     entries;
  logic                 eoi_valid = 1'b0;
  logic [7:0]           eoi_vector = '0;
  logic                 msg_valid;
  logic                 msg_ready = 1'b0;
  logic [31:0]          msg_addr_lo;
  logic [31:0]          msg_addr_hi;
  logic [31:0]          msg_data;
  logic [NP-1:0]        dstat_clr_o;
  logic [NP-1:0]        irr_set_o;
  logic [NP-1:0]        irr_clr_o;
  logic [63:0]          ent [NP];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) entries[i*64 +: 64] = ent[i];
  end

  pin_msg_engine #(.NPINS(NP), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .entries_i(entries),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr_lo(msg_addr_lo), .msg_addr_hi(msg_addr_hi),
    .msg_data(msg_data), .dstat_clr_o(dstat_clr_o), .irr_set_o(irr_set_o),
    .irr_clr_o(irr_clr_o)
  );

  function automatic logic [63:0] mk(input logic [7:0] dest, input logic mask,
      input logic lvl, input logic dstm, input logic [2:0] dm, input logic [7:0] vec);
    logic [63:0] e = '0;
    e[63:56] = dest; e[16] = mask; e[15] = lvl; e[11] = dstm; e[10:8] = dm; e[7:0] = vec;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    @(negedge clk); pin_req = m;
    @(negedge clk); pin_req = '0;
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      if (msg_valid) begin got = 1; return; end
      @(negedge clk);
    end
    got = msg_valid;
  endtask

  task automatic accept(output logic [NP-1:0] ds, output logic [NP-1:0] is);
    @(negedge clk); msg_ready = 1'b1;
    #1; ds = dstat_clr_o; is = irr_set_o;
    @(posedge clk); #1; msg_ready = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v, output logic [NP-1:0] clr);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    #1; clr = irr_clr_o;
    @(posedge clk); #1; eoi_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(msg_valid == 1'b0, "R12 valid after reset", msg_valid, 0);
    chk(dstat_clr_o == '0 && irr_set_o == '0 && irr_clr_o == '0, "R12 strobes after reset",
        {dstat_clr_o, irr_set_o}, 0);
  endtask

  task automatic t_addr;
    bit got; logic [NP-1:0] ds, is;
    logic [31:0] e1, e2;
    ent[5] = mk(8'hA5, 0, 0, 1, 3'b000, 8'h40);
    e1 = BASE | (32'hA5 << 12) | 32'h8 | 32'h4;
    pulse(1 << 5); wait_valid(10, got);
    chk(got, "R1 message appears", got, 1);
    chk(msg_addr_lo == e1, "R1 address low", msg_addr_lo, e1);
    chk(msg_addr_hi == 0, "R1 address high zero", msg_addr_hi, 0);
    accept(ds, is);
    chk(ds == (1 << 5), "R7 dstat strobe pin5", ds, 1 << 5);
    chk(is == 0, "R4 no irr set for edge", is, 0);
    ent[6] = mk(8'hF3, 0, 0, 0, 3'b000, 8'h41);
    e2 = BASE | (32'hF3 << 12) | 32'h8;
    pulse(1 << 6); wait_valid(10, got);
    chk(got && msg_addr_lo == e2, "R10 full destination physical mode", msg_addr_lo, e2);
    accept(ds, is);
  endtask

  task automatic t_data;
    bit got; logic [NP-1:0] ds, is;
    ent[9] = mk(8'h12, 0, 0, 0, 3'b101, 8'h31);
    pulse(1 << 9); wait_valid(10, got);
    chk(got && msg_data == 32'h0000_0531, "R2 data mode 101", msg_data, 32'h531);
    accept(ds, is);
    ent[9] = mk(8'h12, 0, 0, 0, 3'b111, 8'hFF);
    pulse(1 << 9); wait_valid(10, got);
    chk(got && msg_data == 32'h0000_07FF, "R2 data mode 111", msg_data, 32'h7FF);
    accept(ds, is);
  endtask

  task automatic t_mask;
    bit got;
    ent[2] = mk(8'h01, 1, 0, 0, 3'b000, 8'h22);
    pulse(1 << 2); wait_valid(10, got);
    chk(!got, "R3 masked pin silent", got, 0);
    ent[2] = mk(8'h01, 0, 0, 0, 3'b000, 8'h22);
    wait_valid(10, got);
    chk(!got, "R3 masked request discarded", got, 0);
  endtask

  task automatic t_level;
    bit got; logic [NP-1:0] ds, is, clr;
    ent[11] = mk(8'h01, 0, 1, 0, 3'b000, 8'h55);
    ent[12] = mk(8'h02, 0, 0, 0, 3'b000, 8'h55);
    pulse(1 << 11); wait_valid(10, got);
    chk(got && msg_data == 32'h0000_8055, "R4 level data", msg_data, 32'h8055);
    accept(ds, is);
    chk(is == (1 << 11), "R4 irr set strobe", is, 1 << 11);
    chk(ds == (1 << 11), "R7 dstat strobe pin11", ds, 1 << 11);
    pulse(1 << 11); wait_valid(12, got);
    chk(!got, "R5 level pin blocked", got, 0);
    eoi(8'h54, clr);
    chk(clr == 0, "R6 non-matching eoi", clr, 0);
    wait_valid(8, got);
    chk(!got, "R5 still blocked after other vector", got, 0);
    eoi(8'h55, clr);
    chk(clr == (1 << 11), "R6 eoi clears level only", clr, 1 << 11);
    wait_valid(10, got);
    chk(got && msg_data[7:0] == 8'h55, "R5 resent after eoi", msg_data, 32'h8055);
    accept(ds, is);
    eoi(8'h55, clr);
  endtask

  task automatic t_prio;
    bit got; logic [NP-1:0] ds, is;
    ent[3]  = mk(8'h00, 0, 0, 0, 3'b000, 8'h03);
    ent[7]  = mk(8'h00, 0, 0, 0, 3'b000, 8'h07);
    ent[23] = mk(8'h00, 0, 0, 0, 3'b000, 8'h17);
    ent[0]  = mk(8'h00, 0, 0, 0, 3'b000, 8'h10);
    pulse((1 << 7) | (1 << 3) | (1 << 23));
    wait_valid(10, got); chk(got && msg_data[7:0] == 8'h03, "R8 first pin3", msg_data[7:0], 8'h03);
    accept(ds, is);
    wait_valid(10, got); chk(got && msg_data[7:0] == 8'h07, "R8 second pin7", msg_data[7:0], 8'h07);
    accept(ds, is);
    wait_valid(10, got); chk(got && msg_data[7:0] == 8'h17, "R8 third pin23", msg_data[7:0], 8'h17);
    accept(ds, is);
    chk(ds == (1 << 23), "R7 dstat pin23", ds, 1 << 23);
    pulse((1 << 23) | 1);
    wait_valid(10, got); chk(got && msg_data[7:0] == 8'h10, "R8 pin0 over pin23", msg_data[7:0], 8'h10);
    accept(ds, is);
    wait_valid(10, got); accept(ds, is);
  endtask

  task automatic t_hold;
    bit got; logic [NP-1:0] ds, is;
    logic [31:0] a0, d0;
    ent[4] = mk(8'h44, 0, 0, 1, 3'b001, 8'h64);
    pulse(1 << 4); wait_valid(10, got);
    a0 = msg_addr_lo; d0 = msg_data;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(msg_valid && msg_addr_lo == a0 && msg_data == d0, "R9 stable while stalled", msg_data, d0);
      chk(dstat_clr_o == 0, "R7 no strobe while stalled", dstat_clr_o, 0);
    end
    accept(ds, is);
  endtask

  task automatic t_inflight;
    bit got; logic [NP-1:0] ds, is;
    ent[8] = mk(8'h08, 0, 0, 0, 3'b000, 8'h88);
    pulse(1 << 8); wait_valid(10, got);
    pulse(1 << 8);
    accept(ds, is);
    wait_valid(10, got);
    chk(got && msg_data[7:0] == 8'h88, "R11 repeat latched", msg_data[7:0], 8'h88);
    accept(ds, is);
    wait_valid(10, got);
    chk(!got, "R11 only one repeat", got, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) ent[i] = mk(8'h00, 1, 0, 0, 3'b000, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_data();
    t_mask();
    t_level();
    t_prio();
    t_hold();
    t_inflight();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule